// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Steering Router

This block gathers the four interrupt pins (A, B, C, D) of each attached PCI device and folds them onto four shared PCI interrupt lines. Each device is identified by its device/function number; the slot number taken from it decides how the device's pins are rotated before they reach the shared lines. Devices in the four slots starting at a configurable base slot are rotated by their distance from that base. Devices in any other slot keep their pins unrotated.

Each of the four shared lines is then steered to one of `NUM_OUT` interrupt-controller inputs by its own routing register. The level on a controller input is the OR of every shared line whose routing register points at it. The outputs are combinational from the pins and the registered routes, so after a route update the old and new controller inputs both take their new levels in the same cycle.

A small configuration port also holds an interrupt cause register and three mask registers. Hardware events set cause bits. Software clears a cause bit by writing 0 to it. Bit 0 of the cause register is a summary bit, always equal to the OR of bits 31:1. The masks are plain storage with fixed sets of writable bits. All pins are plain level or control signals; nothing here streams data, so there is no valid/ready handshake.

Top module: `irq_swizzle_router`

## Requirements
- R1: For a device whose slot (device/function number bits 7:3) lies in SLOT_BASE..SLOT_BASE+3, pin p (A=0, B=1, C=2, D=3, bit 4*d+p of `dev_pins`) drives shared line ((slot - SLOT_BASE) + p) & 3.
- R2: For a device in any other slot, pin p drives shared line p.
- R3: A shared line is high when any pin of any device that maps to it is high.
- R4: Controller output k equals the OR of the shared lines i whose routing register holds k. A route write moves a line's level off the old output and onto the new one in the cycle after the write edge, with no stale level left behind.
- R5: A rising `cause_evt` bit n (n in 31:1) sets cause bit n. A write to address 0 clears each cause bit 31:1 written as 0 and keeps each bit written as 1. An event on a bit wins over a clear of that bit in the same cycle. Bit 0 of `cause_evt` is ignored.
- R6: Cause bit 0 always equals the OR of cause bits 31:1, whatever value is written to it.
- R7: The CPU mask (address 1) keeps only bits 0x3C3FFFFE of a write, the PCI mask (address 2) keeps 0x03FFFFFE, and the error mask (address 3) keeps 0x0000003F.
- R8: Reset clears the cause register, all three masks and all four routing registers; with all routes 0, every shared line is steered to output 0.
- R9: `cfg_rdata` returns the register selected by `cfg_addr` in the same cycle: 0 cause, 1 CPU mask, 2 PCI mask, 3 error mask, 4+i routing register of line i in bits SEL_W-1:0 with upper bits 0. Addresses 8 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_devfn | input | 8*NUM_DEV | Device/function number of each device; device d in bits 8*d+7:8*d |
| dev_pins | input | 4*NUM_DEV | Interrupt pin levels; pin p of device d at bit 4*d+p |
| cause_evt | input | 32 | Cause event bits 31:1; bit 0 unused |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| irq_out | output | NUM_OUT | Interrupt-controller input levels |

## Verification
The bench builds the router with two devices and four controller outputs, so routing registers are two bits wide and all 256 route settings can be swept against all 16 shared-line patterns. With two devices, one device can be swept across all 32 slots and four pins while the other stays idle. Then both devices can be placed in rotating slots and all 256 pin combinations checked for the OR of R3. A reference model of the cause register runs a pseudo-random mix of events and clearing writes, including events and clears on the same bit in the same cycle.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned CFG_AW    = 4;

  localparam logic [CFG_AW-1:0] ADDR_CAUSE   = 4'd0;
  localparam logic [CFG_AW-1:0] ADDR_CPUMASK = 4'd1;
  localparam logic [CFG_AW-1:0] ADDR_PCIMASK = 4'd2;
  localparam logic [CFG_AW-1:0] ADDR_ERRMASK = 4'd3;
  localparam logic [CFG_AW-1:0] ADDR_ROUTE0  = 4'd4;

  localparam logic [31:0] CPUMASK_KEEP = 32'h3C3F_FFFE;
  localparam logic [31:0] PCIMASK_KEEP = 32'h03FF_FFFE;
  localparam logic [31:0] ERRMASK_KEEP = 32'h0000_003F;

endpackage

// File: rtl/irqr_swizzle.sv
module irqr_swizzle #(
  parameter int unsigned NUM_DEV   = 4,
  parameter int unsigned SLOT_BASE = 18
) (
  input  logic [8*NUM_DEV-1:0] dev_devfn,
  input  logic [4*NUM_DEV-1:0] dev_pins,
  output logic [3:0]           line_lvl
);

  localparam int unsigned SPAN = irqr_pkg::NUM_LINES;

  logic [NUM_DEV-1:0]   dev_hit;
  logic [2*NUM_DEV-1:0] dev_off;

  // Per-device slot decode
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [4:0] slot;
    logic [5:0] slot_rel;
    assign slot     = dev_devfn[8*d+3 +: 5];
    assign slot_rel = {1'b0, slot} - 6'(SLOT_BASE);
    assign dev_hit[d] = (32'(slot) >= 32'(SLOT_BASE)) &&
                        (32'(slot) <  32'(SLOT_BASE + SPAN));
    assign dev_off[2*d +: 2] = slot_rel[1:0];
  end

  // Rotate each pin and merge all devices onto the shared lines
  always_comb begin
    line_lvl = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < 4; p++) begin
        logic [1:0] tgt;
        tgt = dev_hit[d] ? (dev_off[2*d +: 2] + 2'(p)) : 2'(p);
        if (dev_pins[4*d+p]) line_lvl[tgt] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqr_steer.sv
module irqr_steer #(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [3:0]            line_lvl,
  input  logic [3:0][SEL_W-1:0] route,
  output logic [NUM_OUT-1:0]    irq_out
);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic [3:0] sel;
    always_comb begin
      for (int i = 0; i < 4; i++) sel[i] = (route[i] == SEL_W'(k));
    end
    assign irq_out[k] = |(line_lvl & sel);
  end

endmodule

// File: rtl/irqr_regs.sv
module irqr_regs
  import irqr_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           cause_evt,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  output logic [31:0]           cause_q,
  output logic [31:0]           cpumask_q,
  output logic [31:0]           pcimask_q,
  output logic [31:0]           errmask_q,
  output logic [3:0][SEL_W-1:0] route_q
);

  logic        wr_cause;
  logic [31:1] cause_hi;

  assign wr_cause = cfg_we && (cfg_addr == ADDR_CAUSE);

  always_comb begin
    cause_hi = cause_q[31:1];
    if (wr_cause) cause_hi = cause_hi & cfg_wdata[31:1];
    cause_hi = cause_hi | cause_evt[31:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q   <= '0;
      cpumask_q <= '0;
      pcimask_q <= '0;
      errmask_q <= '0;
      route_q   <= '0;
    end else begin
      cause_q <= {cause_hi, |cause_hi};
      if (cfg_we) begin
        case (cfg_addr)
          ADDR_CPUMASK: cpumask_q <= cfg_wdata & CPUMASK_KEEP;
          ADDR_PCIMASK: pcimask_q <= cfg_wdata & PCIMASK_KEEP;
          ADDR_ERRMASK: errmask_q <= cfg_wdata & ERRMASK_KEEP;
          default: begin
            for (int i = 0; i < 4; i++)
              if (cfg_addr == ADDR_ROUTE0 + CFG_AW'(i))
                route_q[i] <= cfg_wdata[SEL_W-1:0];
          end
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      ADDR_CAUSE:   cfg_rdata = cause_q;
      ADDR_CPUMASK: cfg_rdata = cpumask_q;
      ADDR_PCIMASK: cfg_rdata = pcimask_q;
      ADDR_ERRMASK: cfg_rdata = errmask_q;
      default: begin
        for (int i = 0; i < 4; i++)
          if (cfg_addr == ADDR_ROUTE0 + CFG_AW'(i))
            cfg_rdata = 32'(route_q[i]);
      end
    endcase
  end

endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router #(
  parameter int unsigned NUM_DEV   = 4,
  parameter int unsigned NUM_OUT   = 8,
  parameter int unsigned SLOT_BASE = 18,
  localparam int unsigned SEL_W    = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [8*NUM_DEV-1:0] dev_devfn,
  input  logic [4*NUM_DEV-1:0] dev_pins,
  input  logic [31:0]          cause_evt,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic [NUM_OUT-1:0]   irq_out
);

  logic [3:0]            line_lvl;
  logic [3:0][SEL_W-1:0] route_q;
  logic [31:0]           cause_q;
  logic [31:0]           cpumask_q;
  logic [31:0]           pcimask_q;
  logic [31:0]           errmask_q;

  irqr_swizzle #(.NUM_DEV(NUM_DEV), .SLOT_BASE(SLOT_BASE)) u_swz (
    .dev_devfn (dev_devfn),
    .dev_pins  (dev_pins),
    .line_lvl  (line_lvl)
  );

  irqr_steer #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_steer (
    .line_lvl (line_lvl),
    .route    (route_q),
    .irq_out  (irq_out)
  );

  irqr_regs #(.SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cause_evt (cause_evt),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cause_q   (cause_q),
    .cpumask_q (cpumask_q),
    .pcimask_q (pcimask_q),
    .errmask_q (errmask_q),
    .route_q   (route_q)
  );

endmodule

// File: rtl/irqr_checks.sv
module irqr_checks
  import irqr_pkg::*;
#(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned SEL_W   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [31:0]           cause_evt,
  input logic                  cfg_we,
  input logic [3:0]            cfg_addr,
  input logic [31:0]           cfg_wdata,
  input logic [31:0]           cause_q,
  input logic [31:0]           cpumask_q,
  input logic [31:0]           pcimask_q,
  input logic [31:0]           errmask_q,
  input logic [3:0]            line_lvl,
  input logic [3:0][SEL_W-1:0] route_q,
  input logic [NUM_OUT-1:0]    irq_out
);

  a_r6_summary_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[0] == (|cause_q[31:1]));

  a_r5_clear_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_CAUSE && cause_evt[31:1] == '0)
    |=> cause_q[31:1] == ($past(cause_q[31:1]) & $past(cfg_wdata[31:1])));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == ADDR_CAUSE)
    |=> (cause_q[31:1] & $past(cause_q[31:1])) == $past(cause_q[31:1]));

  a_r7_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpumask_q & ~CPUMASK_KEEP) == '0) && ((pcimask_q & ~PCIMASK_KEEP) == '0) &&
    ((errmask_q & ~ERRMASK_KEEP) == '0));

  a_r4_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl == '0) |-> (irq_out == '0));

  for (genvar i = 0; i < 4; i++) begin : g_line
    a_r4_line_reaches: assert property (@(posedge clk) disable iff (!rst_n)
      (line_lvl[i] && (32'(route_q[i]) < NUM_OUT)) |-> irq_out[route_q[i]]);
  end

endmodule

bind irq_swizzle_router irqr_checks #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cause_evt (cause_evt),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cause_q   (cause_q),
  .cpumask_q (cpumask_q),
  .pcimask_q (pcimask_q),
  .errmask_q (errmask_q),
  .line_lvl  (line_lvl),
  .route_q   (route_q),
  .irq_out   (irq_out)
);

// File: tb/tb_irq_swizzle_router.sv
module tb_irq_swizzle_router;

  localparam int NUM_DEV = 2;
  localparam int NUM_OUT = 4;
  localparam int BASE    = 18;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [8*NUM_DEV-1:0] dev_devfn = '0;
  logic [4*NUM_DEV-1:0] dev_pins = '0;
  logic [31:0]        cause_evt = '0;
  logic               cfg_we = 1'b0;
  logic [3:0]         cfg_addr = '0;
  logic [31:0]        cfg_wdata = '0;
  logic [31:0]        cfg_rdata;
  logic [NUM_OUT-1:0] irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_swizzle_router #(.NUM_DEV(NUM_DEV), .NUM_OUT(NUM_OUT), .SLOT_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .dev_devfn(dev_devfn), .dev_pins(dev_pins),
    .cause_evt(cause_evt), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  function automatic int rot(input int slot, input int pin);
    if (slot >= BASE && slot < BASE + 4) return ((slot - BASE) + pin) & 3;
    return pin;
  endfunction

  function automatic logic [3:0] lines_of(input int slot, input logic [3:0] pins);
    logic [3:0] l = '0;
    for (int p = 0; p < 4; p++) if (pins[p]) l[rot(slot, p)] = 1'b1;
    return l;
  endfunction

  function automatic logic [3:0] steer(input logic [3:0] l, input logic [7:0] r);
    logic [3:0] o = '0;
    for (int i = 0; i < 4; i++) if (l[i]) o[r[2*i +: 2]] = 1'b1;
    return o;
  endfunction

  task automatic set_routes(input logic [7:0] r);
    for (int i = 0; i < 4; i++) cfg_write(4'(4 + i), 32'(r[2*i +: 2]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] model;
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    for (int a = 0; a < 8; a++) begin
      cfg_read(4'(a), rd);
      chk("R8 reset register", rd, 32'h0);
    end
    dev_devfn = '0; dev_pins = 8'h0F;
    #1 chk("R8 all routes to output 0", 32'(irq_out), 32'h1);
    dev_pins = '0;

    // R7: mask widths
    cfg_write(4'd1, 32'hFFFF_FFFF); cfg_read(4'd1, rd); chk("R7 cpu mask", rd, 32'h3C3F_FFFE);
    cfg_write(4'd2, 32'hFFFF_FFFF); cfg_read(4'd2, rd); chk("R7 pci mask", rd, 32'h03FF_FFFE);
    cfg_write(4'd3, 32'hFFFF_FFFF); cfg_read(4'd3, rd); chk("R7 err mask", rd, 32'h0000_003F);
    cfg_write(4'd1, 32'hA5A5_5A5B); cfg_read(4'd1, rd); chk("R7 cpu mask pattern", rd, 32'hA5A5_5A5B & 32'h3C3F_FFFE);
    cfg_write(4'd3, 32'h0000_0000); cfg_read(4'd3, rd); chk("R7 err mask clear", rd, 32'h0);

    // R9: unused addresses and route width
    for (int a = 8; a < 16; a++) begin
      cfg_write(4'(a), 32'hFFFF_FFFF);
      cfg_read(4'(a), rd); chk("R9 unused reads zero", rd, 32'h0);
    end
    cfg_read(4'd1, rd); chk("R9 unused write leaves cpu mask", rd, 32'hA5A5_5A5B & 32'h3C3F_FFFE);
    cfg_read(4'd2, rd); chk("R9 unused write leaves pci mask", rd, 32'h03FF_FFFE);
    cfg_write(4'd5, 32'hFFFF_FFFF); cfg_read(4'd5, rd); chk("R9 route field width", rd, 32'h3);

    // R1/R2: every slot and pin of device 0 with identity routes
    set_routes(8'b11_10_01_00);
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        dev_devfn = {8'h00, 5'(s), 3'(s)};
        dev_pins  = 8'(1 << p);
        #1;
        if (s >= BASE && s < BASE + 4)
          chk("R1 rotated slot", 32'(irq_out), 32'(1 << rot(s, p)));
        else
          chk("R2 pass-through slot", 32'(irq_out), 32'(1 << p));
      end
    end

    // R3: two rotating devices, all pin combinations
    dev_devfn = {5'(21), 3'd2, 5'(19), 3'd0};
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        dev_pins = {4'(b), 4'(a)};
        #1 chk("R3 OR of devices", 32'(irq_out),
               32'(lines_of(19, 4'(a)) | lines_of(21, 4'(b))));
      end
    end

    // R4: every route setting with every shared-line pattern
    dev_devfn = {5'(5), 3'd0, 5'(0), 3'd0};
    for (int r = 0; r < 256; r++) begin
      set_routes(8'(r));
      for (int l = 0; l < 16; l++) begin
        dev_pins = {4'h0, 4'(l)};
        #1 chk("R4 steering", 32'(irq_out), 32'(steer(4'(l), 8'(r))));
      end
    end

    // R4: route move leaves no stale level
    set_routes(8'b00_00_00_01);
    dev_pins = 8'h01;
    #1 chk("R4 before move", 32'(irq_out), 32'h2);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'd4; cfg_wdata = 32'd2;
    #1 chk("R4 unchanged before edge", 32'(irq_out), 32'h2);
    @(negedge clk); cfg_we = 1'b0;
    #1 chk("R4 moved after edge", 32'(irq_out), 32'h4);
    dev_pins = '0;

    // R5/R6: directed cause cases
    cfg_addr = 4'd0;
    @(negedge clk); cause_evt = 32'hFFFF_FFFF;
    @(negedge clk); cause_evt = '0;
    cfg_read(4'd0, rd); chk("R5 events set bits, R6 summary", rd, 32'hFFFF_FFFF);
    cfg_write(4'd0, 32'hFFFF_0000); cfg_read(4'd0, rd); chk("R5 write zero clears", rd, 32'hFFFF_0001);
    cfg_write(4'd0, 32'h0000_0001); cfg_read(4'd0, rd); chk("R6 summary drops with bits", rd, 32'h0);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'h0; cause_evt = 32'h0000_0010;
    @(negedge clk); cfg_we = 1'b0; cause_evt = '0;
    cfg_read(4'd0, rd); chk("R5 event beats clear", rd, 32'h0000_0011);
    cfg_write(4'd0, 32'hFFFF_FFFE); cfg_read(4'd0, rd); chk("R6 written bit0 ignored", rd, 32'h0000_0011);
    @(negedge clk); cause_evt = 32'h0000_0001;
    @(negedge clk); cause_evt = '0;
    cfg_write(4'd0, 32'h0); cfg_read(4'd0, rd); chk("R5 evt bit0 ignored", rd, 32'h0);

    // R5/R6: pseudo-random run against a reference model
    model = 32'h0; lfsr = 32'hACE1_1234;
    cfg_addr = 4'd0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      #1 chk("R5 R6 random cause", cfg_rdata, model);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cause_evt = (n % 3 == 0) ? (lfsr & {lfsr[15:0], lfsr[31:16]}) : 32'h0;
      cfg_we    = lfsr[5];
      cfg_wdata = lfsr ^ {lfsr[7:0], lfsr[31:8]};
      begin
        logic [31:1] hi;
        hi = model[31:1];
        if (cfg_we) hi = hi & cfg_wdata[31:1];
        hi = hi | cause_evt[31:1];
        model = {hi, |hi};
      end
    end
    @(negedge clk); cfg_we = 1'b0; cause_evt = '0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule